// File: doc/BRIEF.md
# Half-Cycle Locked Bridge PWM Comparator

This block turns a signed modulation reference and a triangular carrier into the gate commands for the two arms of one H-bridge. It uses the unipolar scheme. The left arm compares the carrier against the midpoint plus the reference. The right arm compares it against the midpoint minus the reference, so its reference is in phase opposition. The reference may move on every clock and is never held until a carrier peak or trough. A fast control loop can therefore update it many times per switching period without adding delay to the PWM edges.

A reference that moves while the carrier passes it can meet the carrier several times within one carrier slope. A plain comparator would then emit narrow glitch pulses. Each arm instead keeps one lock flag for the rising half and one for the falling half. The first meeting in a half moves the output and sets that half's flag. Later meetings in the same half are ignored until the end strobe for that half clears the flag. No pulse-width filter sits in the path, so an edge appears on the clock edge that follows the meeting.

The carrier value, its slope direction and the two end-of-half strobes come from a shared carrier generator outside the block. Dead time is added downstream.

Top module: `halfcycle_pwm_bridge`

## Requirements
- R1: During reset and after reset, both arm outputs are low and all lock flags are clear.
- R2: An arm sees a meeting in a cycle when its compare value equals the carrier value. It also sees one when the comparison "compare value > carrier" differs from the result of the previous clock. This second test applies from the second cycle after reset onward.
- R3: When `carrier_rising_i` is 1, the first meeting while the rising flag is clear drives that arm low and sets the rising flag. The output changes on the next clock edge.
- R4: When `carrier_rising_i` is 0, the first meeting while the falling flag is clear drives that arm high and sets the falling flag. The output changes on the next clock edge.
- R5: While a half's flag is set, further meetings in that half leave the arm output unchanged.
- R6: `rise_done_i` clears the rising flags and `fall_done_i` clears the falling flags. A meeting in the same cycle as the strobe still acts first.
- R7: The left arm compare value is PEAK/2 + `ref_i`. The right arm compare value is PEAK/2 − `ref_i`.
- R8: A reference that jumps across the carrier between two clocks without ever equalling it still produces the edge.
- R9: Each arm output changes at most once between two consecutive end strobes of the same half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| carrier_i | input | CW | Triangular carrier value, 0 to PEAK |
| carrier_rising_i | input | 1 | 1 while the carrier counts up, 0 while it counts down |
| rise_done_i | input | 1 | Strobe on the last cycle of the rising half |
| fall_done_i | input | 1 | Strobe on the last cycle of the falling half |
| ref_i | input | CW+1 | Signed modulation reference, nominally −PEAK/2 to PEAK/2 |
| pwm_left_o | output | 1 | Left arm gate command |
| pwm_right_o | output | 1 | Right arm gate command |

## Verification
The hardest case to reach is a reference that crosses the carrier several times within one slope. This needs the reference to jitter by a few counts right where the carrier is passing. The random stimulus adds small noise to a slowly drifting reference, so repeated crossings happen in most halves, and it occasionally throws in full-range jumps. A directed step makes the reference leap across the carrier with no equal cycle, which exercises the sign-change detection.

// File: rtl/pwm_lock_pkg.sv
package pwm_lock_pkg;

    typedef struct packed {
        logic pwm;
        logic rise_lock;
        logic fall_lock;
        logic above;
        logic primed;
    } arm_state_t;

    localparam int unsigned NUM_ARMS = 2;

endpackage

// File: rtl/pwm_ref_mirror.sv
module pwm_ref_mirror #(
    parameter int unsigned CW   = 10,
    parameter int unsigned PEAK = 500
) (
    input  logic signed [CW:0]   ref_i,
    input  logic        [CW-1:0] carrier_i,
    output logic signed [CW+1:0] car_o,
    output logic signed [CW+1:0] cmp_left_o,
    output logic signed [CW+1:0] cmp_right_o
);
    localparam int unsigned VW   = CW + 2;
    localparam int          HALF = int'(PEAK / 2);

    logic signed [VW-1:0] mid;
    logic signed [VW-1:0] ref_ext;

    always_comb begin
        mid         = VW'(HALF);
        ref_ext     = VW'(ref_i);
        car_o       = $signed({2'b00, carrier_i});
        cmp_left_o  = mid + ref_ext;
        cmp_right_o = mid - ref_ext;
    end

endmodule

// File: rtl/pwm_arm_lock.sv
module pwm_arm_lock
    import pwm_lock_pkg::*;
#(
    parameter int unsigned CW = 10
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic signed [CW+1:0] cmp_i,
    input  logic signed [CW+1:0] car_i,
    input  logic                 rising_i,
    input  logic                 rise_done_i,
    input  logic                 fall_done_i,
    output logic                 pwm_o
);
    arm_state_t st_d, st_q;
    logic       above_now;
    logic       meet;

    always_comb begin
        above_now = (cmp_i > car_i);
        meet      = (cmp_i == car_i) || (st_q.primed && (above_now != st_q.above));

        st_d        = st_q;
        st_d.above  = above_now;
        st_d.primed = 1'b1;

        if (rising_i) begin
            if (meet && !st_q.rise_lock) begin
                st_d.pwm       = 1'b0;
                st_d.rise_lock = 1'b1;
            end
        end else begin
            if (meet && !st_q.fall_lock) begin
                st_d.pwm       = 1'b1;
                st_d.fall_lock = 1'b1;
            end
        end

        if (rise_done_i) begin
            st_d.rise_lock = 1'b0;
        end
        if (fall_done_i) begin
            st_d.fall_lock = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = st_q.pwm;

endmodule

// File: rtl/halfcycle_pwm_bridge.sv
module halfcycle_pwm_bridge
    import pwm_lock_pkg::*;
#(
    parameter int unsigned CW   = 10,
    parameter int unsigned PEAK = 500
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [CW-1:0]        carrier_i,
    input  logic                 carrier_rising_i,
    input  logic                 rise_done_i,
    input  logic                 fall_done_i,
    input  logic signed [CW:0]   ref_i,
    output logic                 pwm_left_o,
    output logic                 pwm_right_o
);
    localparam int unsigned VW = CW + 2;

    logic signed [VW-1:0] car_s;
    logic signed [VW-1:0] cmp_val [NUM_ARMS];
    logic                 pwm_arm [NUM_ARMS];

    pwm_ref_mirror #(
        .CW   (CW),
        .PEAK (PEAK)
    ) u_mirror (
        .ref_i       (ref_i),
        .carrier_i   (carrier_i),
        .car_o       (car_s),
        .cmp_left_o  (cmp_val[0]),
        .cmp_right_o (cmp_val[1])
    );

    for (genvar a = 0; a < NUM_ARMS; a++) begin : g_arm
        pwm_arm_lock #(
            .CW (CW)
        ) u_arm (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .cmp_i       (cmp_val[a]),
            .car_i       (car_s),
            .rising_i    (carrier_rising_i),
            .rise_done_i (rise_done_i),
            .fall_done_i (fall_done_i),
            .pwm_o       (pwm_arm[a])
        );
    end

    assign pwm_left_o  = pwm_arm[0];
    assign pwm_right_o = pwm_arm[1];

endmodule

// File: rtl/pwm_bridge_chk.sv
module pwm_bridge_chk #(
    parameter int unsigned CW   = 10,
    parameter int unsigned PEAK = 500
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [CW-1:0]      carrier_i,
    input logic               carrier_rising_i,
    input logic signed [CW:0] ref_i,
    input logic               pwm_left_o,
    input logic               pwm_right_o
);
    localparam int HALF = int'(PEAK / 2);

    int  l_cmp, r_cmp, car;
    logic l_above, r_above, l_eq, r_eq;

    always_comb begin
        car     = int'(carrier_i);
        l_cmp   = HALF + int'(ref_i);
        r_cmp   = HALF - int'(ref_i);
        l_above = l_cmp > car;
        r_above = r_cmp > car;
        l_eq    = l_cmp == car;
        r_eq    = r_cmp == car;
    end

    // R1
    reset_low_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!pwm_left_o && !pwm_right_o));

    // R3
    rise_no_up_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(carrier_rising_i) |-> !$rose(pwm_left_o));

    // R3
    rise_no_up_right_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(carrier_rising_i) |-> !$rose(pwm_right_o));

    // R4
    fall_no_down_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(carrier_rising_i) |-> !$fell(pwm_left_o));

    // R4
    fall_no_down_right_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(carrier_rising_i) |-> !$fell(pwm_right_o));

    // R2
    left_move_needs_meet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(pwm_left_o) |-> ($past(l_eq) || ($past(l_above) != $past(l_above, 2))));

    // R2
    right_move_needs_meet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(pwm_right_o) |-> ($past(r_eq) || ($past(r_above) != $past(r_above, 2))));

endmodule

bind halfcycle_pwm_bridge pwm_bridge_chk #(
    .CW   (CW),
    .PEAK (PEAK)
) u_chk (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .carrier_i        (carrier_i),
    .carrier_rising_i (carrier_rising_i),
    .ref_i            (ref_i),
    .pwm_left_o       (pwm_left_o),
    .pwm_right_o      (pwm_right_o)
);

// File: tb/sim_halfcycle_pwm_bridge.sv
`timescale 1ns/1ps
module sim_halfcycle_pwm_bridge;
    localparam int CW   = 7;
    localparam int PEAK = 64;
    localparam int HALF = PEAK / 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [CW-1:0]      carrier = '0;
    logic               rising = 1'b0;
    logic               rdone = 1'b0;
    logic               fdone = 1'b0;
    logic signed [CW:0] ref_v = '0;
    logic               pwm_l, pwm_r;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    halfcycle_pwm_bridge #(.CW(CW), .PEAK(PEAK)) u0 (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .carrier_i        (carrier),
        .carrier_rising_i (rising),
        .rise_done_i      (rdone),
        .fall_done_i      (fdone),
        .ref_i            (ref_v),
        .pwm_left_o       (pwm_l),
        .pwm_right_o      (pwm_r)
    );

    // expected-value model built from the requirements
    bit m_pwm [2], m_rl [2], m_fl [2], m_ab [2];
    bit m_primed;

    function automatic bit meets(int cmpv, int carv, bit prev_ab, bit primed);
        return (cmpv == carv) || (primed && ((cmpv > carv) != prev_ab));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < 2; a++) begin
                m_pwm[a] = 0; m_rl[a] = 0; m_fl[a] = 0; m_ab[a] = 0;
            end
            m_primed = 0;
        end else begin
            for (int a = 0; a < 2; a++) begin
                int cv;
                bit mt;
                cv = (a == 0) ? HALF + int'(ref_v) : HALF - int'(ref_v);
                mt = meets(cv, int'(carrier), m_ab[a], m_primed);
                if (rising && mt && !m_rl[a]) begin m_pwm[a] = 0; m_rl[a] = 1; end
                if (!rising && mt && !m_fl[a]) begin m_pwm[a] = 1; m_fl[a] = 1; end
                if (rdone) m_rl[a] = 0;
                if (fdone) m_fl[a] = 0;
                m_ab[a] = cv > int'(carrier);
            end
            m_primed = 1;
        end
    end

    // per-cycle comparison and per-half change counting
    bit run_chk = 0;
    bit last_l = 0, last_r = 0;
    int cnt_rise [2], cnt_fall [2];

    always @(negedge clk) begin
        if (run_chk && rst_n) begin
            checks++;
            if (pwm_l !== m_pwm[0] || pwm_r !== m_pwm[1]) begin
                errors++;
                $display("FAIL R2 R3 R4 R5 R6 R7 t=%0t actual L=%0b R=%0b expected L=%0b R=%0b",
                         $time, pwm_l, pwm_r, m_pwm[0], m_pwm[1]);
            end
            if (rising) begin
                cnt_rise[0] += int'(pwm_l != last_l);
                cnt_rise[1] += int'(pwm_r != last_r);
            end else begin
                cnt_fall[0] += int'(pwm_l != last_l);
                cnt_fall[1] += int'(pwm_r != last_r);
            end
            if (rdone) begin
                for (int a = 0; a < 2; a++) begin
                    checks++;
                    if (cnt_rise[a] > 1) begin
                        errors++;
                        $display("FAIL R9 arm %0d rising half actual %0d changes expected <=1", a, cnt_rise[a]);
                    end
                    cnt_rise[a] = 0;
                end
            end
            if (fdone) begin
                for (int a = 0; a < 2; a++) begin
                    checks++;
                    if (cnt_fall[a] > 1) begin
                        errors++;
                        $display("FAIL R9 arm %0d falling half actual %0d changes expected <=1", a, cnt_fall[a]);
                    end
                    cnt_fall[a] = 0;
                end
            end
        end
        last_l = pwm_l;
        last_r = pwm_r;
    end

    task automatic drive_phase(int k);
        if (k < PEAK) begin
            carrier = CW'(k);
            rising  = 1'b1;
            rdone   = (k == PEAK - 1);
            fdone   = 1'b0;
        end else begin
            carrier = CW'(2 * PEAK - k);
            rising  = 1'b0;
            rdone   = 1'b0;
            fdone   = (k == 2 * PEAK - 1);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int base;
        int seed;
        int rv;
        seed = $urandom(32'h5eed_1234);
        carrier = CW'(40);
        rising  = 1'b0;
        ref_v   = -8'sd30;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs low while reset is held
        checks++;
        if (pwm_l !== 1'b0 || pwm_r !== 1'b0) begin
            errors++;
            $display("FAIL R1 in reset actual L=%0b R=%0b expected 0 0", pwm_l, pwm_r);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        run_chk = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: still low after release with no meeting
        checks++;
        if (pwm_l !== 1'b0 || pwm_r !== 1'b0) begin
            errors++;
            $display("FAIL R1 after reset actual L=%0b R=%0b expected 0 0", pwm_l, pwm_r);
        end
        // R8: jump across the carrier in the falling half, no equal cycle
        @(posedge clk); #1;
        carrier = CW'(39);
        ref_v   = 8'sd20;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (pwm_l !== 1'b1 || pwm_r !== 1'b1) begin
            errors++;
            $display("FAIL R8 jump edge actual L=%0b R=%0b expected 1 1", pwm_l, pwm_r);
        end
        // R5: another jump in the same falling half is ignored
        @(posedge clk); #1;
        carrier = CW'(38);
        ref_v   = -8'sd25;
        @(posedge clk); #1;
        ref_v   = 8'sd20;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (pwm_l !== 1'b1 || pwm_r !== 1'b1) begin
            errors++;
            $display("FAIL R5 locked half actual L=%0b R=%0b expected 1 1", pwm_l, pwm_r);
        end
        // R6: close the falling half, then a rising-half meeting pulls left low
        @(posedge clk); #1;
        carrier = CW'(1);
        fdone   = 1'b1;
        @(posedge clk); #1;
        fdone   = 1'b0;
        rising  = 1'b1;
        carrier = CW'(2);
        ref_v   = 8'sd20;
        @(posedge clk); #1;
        carrier = CW'(52);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (pwm_l !== 1'b0) begin
            errors++;
            $display("FAIL R6 R3 rising meet actual L=%0b expected 0", pwm_l);
        end
        // R7: right compare is 12, still above 52? no: 12 < 52, sign flipped at first step
        // realign the carrier with a fresh rising half before random running
        @(posedge clk); #1;
        carrier = CW'(PEAK - 1);
        rdone   = 1'b1;
        @(posedge clk); #1;
        rdone   = 1'b0;
        // random section: drifting reference with jitter and occasional jumps
        base = 0;
        for (int p = 0; p < 40; p++) begin
            for (int k = 0; k < 2 * PEAK; k++) begin
                drive_phase(k);
                if ((k % 16) == 0) base = base + int'($urandom_range(0, 6)) - 3;
                if (base > HALF - 4) base = HALF - 4;
                if (base < -HALF + 4) base = -HALF + 4;
                if ($urandom_range(0, 49) == 0) begin
                    rv = int'($urandom_range(0, PEAK)) - HALF;
                end else begin
                    rv = base + int'($urandom_range(0, 6)) - 3;
                end
                ref_v = (CW + 1)'(rv);
                @(posedge clk); #1;
            end
        end
        // R7: constant positive reference gives a wider left pulse than right
        begin
            int hl, hr;
            hl = 0; hr = 0;
            ref_v = 8'sd10;
            for (int p = 0; p < 3; p++) begin
                for (int k = 0; k < 2 * PEAK; k++) begin
                    drive_phase(k);
                    @(posedge clk); #1;
                    if (p == 2) begin
                        hl += int'(pwm_l);
                        hr += int'(pwm_r);
                    end
                end
            end
            checks++;
            if (hl != 2 * (HALF + 10) || hr != 2 * (HALF - 10)) begin
                errors++;
                $display("FAIL R7 high cycles actual L=%0d R=%0d expected L=%0d R=%0d",
                         hl, hr, 2 * (HALF + 10), 2 * (HALF - 10));
            end
        end
        @(negedge clk);
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule